// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block keeps the pointers and counts for a circular queue of fixed-size descriptors. Software fills the queue and a DMA execution engine works through it. Software uses a small word-addressed register port. Through it, software sets the ring length and the entry format, hands over batches of descriptors by writing a count, releases finished descriptors by writing a count, and starts or halts fetching. It can also read back packed status words.

The block holds three ring pointers. The write pointer is the next slot software fills. The fetch pointer is the next slot the engine takes. The read pointer is the oldest completed slot not yet released. The block raises a fetch request while descriptors are waiting and fetching is enabled, and it counts single-cycle completion pulses from the engine.

Descriptor storage, bus fetching and the execution datapath live elsewhere. The ring length is bounded by a parameter, so wraparound can be exercised with a small ring.

Top module: `desq_ptr_mgr`

## Requirements
- R1: After reset the block is halted (offset 4 reads 1), the format reads 1, the length reads 0, both status words read 0 and `fetch_req_o` is low.
- R2: The effective depth is the programmed length (offset 0, bits [15:0]) when that length is between 1 and the format maximum, and the format maximum otherwise. The maximum is 2^PTR_W for format code 1 and 2^(PTR_W-2) for format code 7. Every pointer wraps to zero on reaching the depth.
- R3: Writing N (bits [15:0]) to offset 2 advances the write pointer by N modulo the depth and adds N to the pending count. The allocation status word (offset 6) returns the write pointer in bits [31:16] and zero in bits [15:0].
- R4: `fetch_req_o` is high exactly when the pending count is nonzero and the block is not halted. `fetch_idx_o` shows the fetch pointer. `fetch_ack_i` while the request is high advances the fetch pointer by one and lowers the pending count by one. Offset 4 bit 0 halts fetching when 1 and enables it when 0.
- R5: Writing N (bits [15:0]) to offset 3 releases min(N, done count) descriptors. The done count drops by that amount and the read pointer advances by the same amount, with wrap.
- R6: Each `done_i` cycle adds one to the done count, including while halted. A `done_i` pulse and a release in the same cycle both take effect.
- R7: The done status word (offset 5) holds the done count in bits [14:0] and the read pointer in bits [28:16]. All other bits are zero.
- R8: Offset 1 accepts only the values 1 (32-byte entries) and 7 (128-byte entries). Any other value leaves the format and all pointers unchanged. A read returns the current code.
- R9: A write to offset 0, or an accepted write to offset 1, returns all three pointers and the pending and done counts to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| fetch_req_o | output | 1 | Descriptor waiting and fetching enabled |
| fetch_idx_o | output | PTR_W | Slot index to fetch |
| fetch_ack_i | input | 1 | Engine took the presented slot |
| done_i | input | 1 | Engine finished one descriptor |

## Verification
The hardest state to reach is one where both the read pointer and the fetch pointer have wrapped while a release asks for more than has completed. To get there, the bench programs a five-entry ring and adds two batches whose sum passes the end of the ring. It then fetches and completes every entry and releases in two steps, the second one oversized, so the clamp and the wrap land on the same write. Completion pulses are also sent while halted, and in the same cycle as a release, to show that the two update paths into the done count combine correctly.

// File: rtl/dq_pkg.sv
package dq_pkg;
  localparam logic [2:0] A_LEN   = 3'd0;
  localparam logic [2:0] A_FMT   = 3'd1;
  localparam logic [2:0] A_ADD   = 3'd2;
  localparam logic [2:0] A_REL   = 3'd3;
  localparam logic [2:0] A_HALT  = 3'd4;
  localparam logic [2:0] A_DONE  = 3'd5;
  localparam logic [2:0] A_ALLOC = 3'd6;

  localparam int unsigned CNT_W  = 16;
  localparam int unsigned DONE_W = 15;
  localparam int unsigned RDF_W  = 13;

  typedef enum logic [2:0] {
    FMT_SMALL = 3'd1,
    FMT_LARGE = 3'd7
  } fmt_e;
endpackage

// File: rtl/dq_cfg.sv
module dq_cfg
  import dq_pkg::*;
#(
  parameter int unsigned PTR_W = 4,
  localparam int unsigned DEPTH_W = PTR_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [2:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic               halt_o,
  output fmt_e               fmt_o,
  output logic [CNT_W-1:0]   len_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               clr_o
);
  logic             halt_q;
  fmt_e             fmt_q;
  logic [CNT_W-1:0] len_q;
  logic             fmt_ok;
  logic [DEPTH_W-1:0] max_d;
  logic             len_ok;

  assign fmt_ok = (wdata_i == 32'(FMT_SMALL)) || (wdata_i == 32'(FMT_LARGE));
  // geometry change restarts the ring
  assign clr_o  = we_i && ((addr_i == A_LEN) || (addr_i == A_FMT && fmt_ok));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= 1'b1;
      fmt_q  <= FMT_SMALL;
      len_q  <= '0;
    end else if (we_i) begin
      if (addr_i == A_LEN) len_q <= wdata_i[CNT_W-1:0];
      if (addr_i == A_FMT && fmt_ok) fmt_q <= fmt_e'(wdata_i[2:0]);
      if (addr_i == A_HALT) halt_q <= wdata_i[0];
    end
  end

  assign max_d   = (fmt_q == FMT_LARGE) ? DEPTH_W'(1 << (PTR_W - 2)) : DEPTH_W'(1 << PTR_W);
  assign len_ok  = (len_q != '0) && ({1'b0, len_q} <= (CNT_W+1)'(max_d));
  assign depth_o = len_ok ? DEPTH_W'(len_q) : max_d;
  assign halt_o  = halt_q;
  assign fmt_o   = fmt_q;
  assign len_o   = len_q;
endmodule

// File: rtl/dq_ring_ptr.sv
module dq_ring_ptr #(
  parameter int unsigned PTR_W = 4,
  parameter int unsigned N_W   = 16,
  localparam int unsigned DEPTH_W = PTR_W + 1,
  localparam int unsigned SUM_W   = PTR_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               adv_i,
  input  logic [N_W-1:0]     n_i,
  input  logic [DEPTH_W-1:0] depth_i,
  output logic [PTR_W-1:0]   ptr_o
);
  logic [PTR_W-1:0]   ptr_q;
  logic [DEPTH_W-1:0] step;
  logic [SUM_W-1:0]   sum, nxt;

  // step is below depth, so one conditional subtract wraps
  assign step = DEPTH_W'(n_i % N_W'(depth_i));
  assign sum  = SUM_W'(ptr_q) + SUM_W'(step);
  assign nxt  = (sum >= SUM_W'(depth_i)) ? sum - SUM_W'(depth_i) : sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (clr_i)  ptr_q <= '0;
    else if (adv_i)  ptr_q <= PTR_W'(nxt);
  end

  assign ptr_o = ptr_q;

  // R2
  ptr_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    SUM_W'(ptr_q) < SUM_W'(depth_i));
  // R3
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(ptr_q));
endmodule

// File: rtl/dq_done_cnt.sv
module dq_done_cnt
  import dq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  input  logic              rel_i,
  input  logic [CNT_W-1:0]  rel_n_i,
  output logic [DONE_W-1:0] cnt_o,
  output logic [CNT_W-1:0]  rel_eff_o
);
  logic [DONE_W-1:0] cnt_q;
  logic [CNT_W-1:0]  rel_eff;
  logic [CNT_W-1:0]  nxt;

  // oversized release is clamped to what has completed
  assign rel_eff = !rel_i ? '0 :
                   (rel_n_i > CNT_W'(cnt_q)) ? CNT_W'(cnt_q) : rel_n_i;
  assign nxt     = CNT_W'(cnt_q) - rel_eff + CNT_W'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= DONE_W'(nxt);
  end

  assign cnt_o     = cnt_q;
  assign rel_eff_o = rel_eff;

  // R5
  done_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && !inc_i && !clr_i) |=> cnt_q <= $past(cnt_q));
  // R6
  done_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !rel_i && !clr_i && cnt_q != '1) |=> cnt_q == $past(cnt_q) + 15'd1);
endmodule

// File: rtl/desq_ptr_mgr.sv
module desq_ptr_mgr
  import dq_pkg::*;
#(
  parameter int unsigned PTR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             fetch_req_o,
  output logic [PTR_W-1:0] fetch_idx_o,
  input  logic             fetch_ack_i,
  input  logic             done_i
);
  localparam int unsigned DEPTH_W = PTR_W + 1;

  logic               halt, clr;
  fmt_e               fmt;
  logic [CNT_W-1:0]   len;
  logic [DEPTH_W-1:0] depth;
  logic               add_en, rel_en, fire;
  logic [CNT_W-1:0]   wcnt, rel_eff, pend_q;
  logic [PTR_W-1:0]   wr_ptr, fe_ptr, rd_ptr;
  logic [DONE_W-1:0]  done_cnt;

  assign wcnt   = reg_wdata_i[CNT_W-1:0];
  assign add_en = reg_we_i && (reg_addr_i == A_ADD);
  assign rel_en = reg_we_i && (reg_addr_i == A_REL);

  dq_cfg #(.PTR_W(PTR_W)) i_cfg (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .halt_o(halt), .fmt_o(fmt), .len_o(len), .depth_o(depth), .clr_o(clr)
  );

  dq_ring_ptr #(.PTR_W(PTR_W), .N_W(CNT_W)) i_wr_ptr (
    .clk_i, .rst_ni, .clr_i(clr), .adv_i(add_en), .n_i(wcnt),
    .depth_i(depth), .ptr_o(wr_ptr)
  );

  dq_ring_ptr #(.PTR_W(PTR_W), .N_W(CNT_W)) i_fe_ptr (
    .clk_i, .rst_ni, .clr_i(clr), .adv_i(fire), .n_i(CNT_W'(1)),
    .depth_i(depth), .ptr_o(fe_ptr)
  );

  dq_ring_ptr #(.PTR_W(PTR_W), .N_W(CNT_W)) i_rd_ptr (
    .clk_i, .rst_ni, .clr_i(clr), .adv_i(rel_en), .n_i(rel_eff),
    .depth_i(depth), .ptr_o(rd_ptr)
  );

  dq_done_cnt i_done (
    .clk_i, .rst_ni, .clr_i(clr), .inc_i(done_i), .rel_i(rel_en),
    .rel_n_i(wcnt), .cnt_o(done_cnt), .rel_eff_o(rel_eff)
  );

  assign fetch_req_o = (pend_q != '0) && !halt;
  assign fetch_idx_o = fe_ptr;
  assign fire        = fetch_req_o && fetch_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  pend_q <= '0;
    else if (clr) pend_q <= '0;
    else          pend_q <= pend_q + (add_en ? wcnt : '0) - CNT_W'(fire);
  end

  always_comb begin
    unique case (reg_addr_i)
      A_LEN:   reg_rdata_o = {16'h0, len};
      A_FMT:   reg_rdata_o = {29'h0, fmt};
      A_HALT:  reg_rdata_o = {31'h0, halt};
      A_DONE:  reg_rdata_o = {3'b0, RDF_W'(rd_ptr), 1'b0, done_cnt};
      A_ALLOC: reg_rdata_o = {CNT_W'(wr_ptr), 16'h0};
      default: reg_rdata_o = '0;
    endcase
  end

  // R4
  fetch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && !clr) |=> $stable(fe_ptr));
  // R4
  pend_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !add_en && !clr) |=> pend_q == $past(pend_q) - 16'd1);
endmodule

// File: tb/test_desq_ptr_mgr.sv
module test_desq_ptr_mgr;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned PTR_W = 4;

  logic             clk = 0, rst_n = 0;
  logic             we = 0, ack = 0, done = 0;
  logic [2:0]       addr = 0;
  logic [31:0]      wdata = 0, rdata;
  logic             req;
  logic [PTR_W-1:0] idx;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  desq_ptr_mgr #(.PTR_W(PTR_W)) i_desq_ptr_mgr (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .fetch_req_o(req),
    .fetch_idx_o(idx), .fetch_ack_i(ack), .done_i(done)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd_chk(input string r, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    chk(r, rdata, exp);
  endtask

  task automatic fetch_one(input string r, input int exp_idx);
    @(negedge clk);
    chk(r, {31'h0, req}, 32'h1);
    chk(r, 32'(idx), 32'(exp_idx));
    ack = 1;
    @(negedge clk); ack = 0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); done = 1;
      @(negedge clk); done = 0;
    end
  endtask

  task automatic t_reset;
    rd_chk("R1 halt", 3'd4, 32'h1);
    rd_chk("R1 fmt", 3'd1, 32'h1);
    rd_chk("R1 len", 3'd0, 32'h0);
    rd_chk("R1 done", 3'd5, 32'h0);
    rd_chk("R1 alloc", 3'd6, 32'h0);
    chk("R1 req", {31'h0, req}, 32'h0);
  endtask

  task automatic t_basic;
    wr(3'd4, 0);
    wr(3'd2, 3);
    rd_chk("R3 alloc", 3'd6, 32'h0003_0000);
    for (int i = 0; i < 3; i++) fetch_one("R4 fetch", i);
    @(negedge clk);
    chk("R4 req low when empty", {31'h0, req}, 32'h0);
  endtask

  task automatic t_halt;
    wr(3'd4, 1);
    wr(3'd2, 2);
    @(negedge clk);
    chk("R4 halted req", {31'h0, req}, 32'h0);
    pulse(2);
    rd_chk("R6 done while halted", 3'd5, 32'h0000_0002);
    wr(3'd4, 0);
    fetch_one("R4 resume", 3);
    fetch_one("R4 resume", 4);
  endtask

  task automatic t_wrap;
    wr(3'd0, 5);
    rd_chk("R9 clear", 3'd5, 32'h0);
    wr(3'd2, 4);
    wr(3'd2, 3);
    rd_chk("R2 wr wrap", 3'd6, 32'h0002_0000);
    for (int i = 0; i < 7; i++) fetch_one("R2 fetch wrap", i % 5);
    @(negedge clk);
    chk("R4 drained", {31'h0, req}, 32'h0);
    pulse(7);
    rd_chk("R7 done7", 3'd5, 32'h0000_0007);
    wr(3'd3, 3);
    rd_chk("R5 release", 3'd5, 32'h0003_0004);
    wr(3'd3, 10);
    rd_chk("R5 clamp wrap", 3'd5, 32'h0002_0000);
    pulse(3);
    @(negedge clk); we = 1; addr = 3'd3; wdata = 1; done = 1;
    @(negedge clk); we = 0; done = 0;
    rd_chk("R6 same-cycle", 3'd5, 32'h0003_0003);
  endtask

  task automatic t_fmt;
    wr(3'd1, 3);
    rd_chk("R8 bad code", 3'd1, 32'h1);
    rd_chk("R8 no clear", 3'd6, 32'h0002_0000);
    wr(3'd1, 7);
    rd_chk("R8 code7", 3'd1, 32'h7);
    rd_chk("R9 fmt clear", 3'd5, 32'h0);
    wr(3'd2, 6);
    rd_chk("R2 large max", 3'd6, 32'h0002_0000);
    fetch_one("R4 after fmt", 0);
    wr(3'd1, 1);
    wr(3'd0, 0);
    wr(3'd2, 17);
    rd_chk("R2 small max", 3'd6, 32'h0001_0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_basic;
    t_halt;
    t_wrap;
    t_fmt;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule